// File: doc/BRIEF.md
# Per-Core Memory Bandwidth Regulator

This block holds every core of a multicore cluster to a budget of memory transactions per regulation period. Each cycle a core may present one transaction event on its `access_i` bit (a last-level cache miss, for instance). Events that arrive while the core's `stall_o` bit is low are accepted and counted. While a core's remaining budget is above zero it runs. When the remaining budget reaches zero, the regulator raises that core's stall. The stall stands in for taking the core's tasks off the run queue.

At each period boundary a soft core predicts its next usage from the count it accepted in the period just ended. It keeps only that much of its assigned budget and gives the rest to a shared pool. The pool is rebuilt from scratch at every boundary. A soft core that runs dry while it still has demand draws fixed quanta from the pool. A hard core takes no part in donation or reclaim and starts every period with its full budget. When every core is dry and the pool is empty, all stalls drop and the cluster runs best-effort until the period ends. Budgets arrive per core as inputs and may be weighted freely (for example 1:2:4:8). System software keeps their sum within the guaranteed DRAM bandwidth.

Top module: `mem_bw_regulator`

## Requirements
- R1: After reset, `stall_o` and `best_effort_o` are low until the first period boundary, which falls on the first clock edge after reset release. Later boundaries follow every `PERIOD_CYCLES` cycles. No donation happens at the first boundary.
- R2: A core whose remaining budget is zero holds `stall_o` high until it receives a grant, best-effort mode begins or the period ends. An accepted event lowers the remaining budget by one.
- R3: At each later boundary, a soft core's remaining budget becomes `min(budget, u)`, where u is the number of events it accepted in the period just ended.
- R4: At each boundary the pool is loaded with the sum of the soft cores' surpluses, `max(0, budget - u)`. Whatever was left in the pool from the previous period is discarded.
- R5: A soft core with zero budget and `access_i` high requests a grant. At most one request is granted per cycle, lowest core index first, provided the pool is non-empty. The grant is `min(QUANTUM, pool)` and it releases the core's stall in the following cycle.
- R6: A hard core (its `hard_i` bit high) starts every period with its full budget, is never stalled before it has accepted that many events in the period, and is never granted from the pool.
- R7: When every core's remaining budget is zero and the pool is empty, `best_effort_o` is high and every `stall_o` bit is low until the period ends.
- R8: Events presented while a core is stalled are not accepted. Events accepted in best-effort mode count toward that core's usage for prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| access_i | input | NUM_CORES | One memory transaction event per core per cycle |
| hard_i | input | NUM_CORES | Per-core select: 1 = hard reservation, 0 = soft |
| budget_i | input | NUM_CORES*CNT_W | Per-core assigned budget per period; core i at bits [i*CNT_W +: CNT_W] |
| stall_o | output | NUM_CORES | Per-core stall request |
| best_effort_o | output | 1 | All cores released into best-effort mode |

## Verification
The hardest state to reach from the ports is contention for the pool. Several soft cores must go dry in the same cycles while the pool holds surplus from an earlier period. The bench gets there in two steps. It first runs a period in which only one core is busy, so that the idle cores donate their whole budget. It then raises demand on every core at once and checks the stall pattern cycle by cycle to confirm lowest-index-first grants. Pool clearing is shown by leaving a large pool unused for a period. The bench then reconfigures so that only a two-event surplus refills the pool and checks that the starving core gets exactly those two events.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
  // period phase flags shared by the per-core and pool logic
  typedef struct packed {
    logic boundary;  // last cycle of the period: loads happen on its edge
    logic first;     // between reset and the first boundary
  } mbr_epoch_t;
endpackage

// File: rtl/mbr_period_timer.sv
module mbr_period_timer
  import mbr_pkg::*;
#(
  parameter int PERIOD_CYCLES = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output mbr_epoch_t epoch_o
);
  localparam int CW = (PERIOD_CYCLES > 1) ? $clog2(PERIOD_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          first_q;
  logic          boundary;

  assign boundary = (cnt_q == LAST);

  // reset parks the counter on the last cycle so the first edge is a boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= LAST;
      first_q <= 1'b1;
    end else begin
      cnt_q <= boundary ? '0 : cnt_q + 1'b1;
      if (boundary) first_q <= 1'b0;
    end
  end

  assign epoch_o.boundary = boundary;
  assign epoch_o.first    = first_q;
endmodule

// File: rtl/mbr_core_acct.sv
module mbr_core_acct
  import mbr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  mbr_epoch_t       epoch_i,
  input  logic             access_i,
  input  logic             hard_i,
  input  logic [CNT_W-1:0] budget_i,
  input  logic             best_effort_i,
  input  logic             grant_i,
  input  logic [CNT_W-1:0] grant_amt_i,
  output logic [CNT_W-1:0] surplus_o,
  output logic             req_o,
  output logic             empty_o,
  output logic             stall_o
);
  logic [CNT_W-1:0] used_q, used_nx, rem_q, pred;
  logic             acc;

  assign empty_o = (rem_q == '0);
  assign stall_o = empty_o && !best_effort_i && !epoch_i.first;
  assign acc     = access_i && !stall_o;
  assign used_nx = (acc && used_q != '1) ? used_q + 1'b1 : used_q;

  // prediction: last period's usage; no history before the first boundary
  assign pred      = epoch_i.first ? budget_i : used_nx;
  assign surplus_o = (!hard_i && budget_i > pred) ? budget_i - pred : '0;
  assign req_o     = !hard_i && empty_o && access_i && !epoch_i.first;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_q <= '0;
      rem_q  <= '0;
    end else if (epoch_i.boundary) begin
      used_q <= '0;
      rem_q  <= budget_i - surplus_o;
    end else begin
      used_q <= used_nx;
      if (acc && !empty_o) rem_q <= rem_q - 1'b1;
      else if (grant_i)    rem_q <= rem_q + grant_amt_i;
    end
  end
endmodule

// File: rtl/mbr_reclaim_pool.sv
module mbr_reclaim_pool
  import mbr_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CNT_W     = 8,
  parameter int QUANTUM   = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  mbr_epoch_t                 epoch_i,
  input  logic [NUM_CORES*CNT_W-1:0] surplus_i,
  input  logic [NUM_CORES-1:0]       req_i,
  output logic [NUM_CORES-1:0]       grant_o,
  output logic [CNT_W-1:0]           grant_amt_o,
  output logic                       pool_empty_o
);
  localparam int PW = CNT_W + ((NUM_CORES > 1) ? $clog2(NUM_CORES) : 1);
  localparam logic [PW-1:0] QPW = PW'(QUANTUM);

  logic [PW-1:0] pool_q, donated;
  logic          found;

  assign pool_empty_o = (pool_q == '0);

  always_comb begin
    donated = '0;
    for (int i = 0; i < NUM_CORES; i++)
      donated = donated + PW'(surplus_i[i*CNT_W +: CNT_W]);
  end

  // fixed priority, lowest index wins
  always_comb begin
    grant_o = '0;
    found   = 1'b0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (req_i[i] && !found && !pool_empty_o) begin
        grant_o[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  assign grant_amt_o = (pool_q < QPW) ? pool_q[CNT_W-1:0] : CNT_W'(QUANTUM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               pool_q <= '0;
    else if (epoch_i.boundary) pool_q <= donated;
    else if (found)            pool_q <= pool_q - PW'(grant_amt_o);
  end
endmodule

// File: rtl/mem_bw_regulator.sv
module mem_bw_regulator
  import mbr_pkg::*;
#(
  parameter int NUM_CORES     = 4,
  parameter int CNT_W         = 8,
  parameter int PERIOD_CYCLES = 32,
  parameter int QUANTUM       = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_CORES-1:0]       access_i,
  input  logic [NUM_CORES-1:0]       hard_i,
  input  logic [NUM_CORES*CNT_W-1:0] budget_i,
  output logic [NUM_CORES-1:0]       stall_o,
  output logic                       best_effort_o
);
  mbr_epoch_t                 epoch_w;
  logic [NUM_CORES*CNT_W-1:0] surplus_w;
  logic [NUM_CORES-1:0]       req_w, grant_w, empty_w;
  logic [CNT_W-1:0]           grant_amt_w;
  logic                       pool_empty_w;

  assign best_effort_o = (&empty_w) && pool_empty_w && !epoch_w.first;

  mbr_period_timer #(.PERIOD_CYCLES(PERIOD_CYCLES)) timer_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .epoch_o (epoch_w)
  );

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    mbr_core_acct #(.CNT_W(CNT_W)) acct_i (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .epoch_i       (epoch_w),
      .access_i      (access_i[g]),
      .hard_i        (hard_i[g]),
      .budget_i      (budget_i[g*CNT_W +: CNT_W]),
      .best_effort_i (best_effort_o),
      .grant_i       (grant_w[g]),
      .grant_amt_i   (grant_amt_w),
      .surplus_o     (surplus_w[g*CNT_W +: CNT_W]),
      .req_o         (req_w[g]),
      .empty_o       (empty_w[g]),
      .stall_o       (stall_o[g])
    );
  end

  mbr_reclaim_pool #(
    .NUM_CORES (NUM_CORES),
    .CNT_W     (CNT_W),
    .QUANTUM   (QUANTUM)
  ) pool_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .epoch_i      (epoch_w),
    .surplus_i    (surplus_w),
    .req_i        (req_w),
    .grant_o      (grant_w),
    .grant_amt_o  (grant_amt_w),
    .pool_empty_o (pool_empty_w)
  );
endmodule

// File: rtl/mem_bw_regulator_chk.sv
module mem_bw_regulator_chk #(
  parameter int NUM_CORES = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_CORES-1:0] hard_i,
  input logic [NUM_CORES-1:0] stall_o,
  input logic                 best_effort_o,
  input logic [NUM_CORES-1:0] grant_i,
  input logic                 boundary_i,
  input logic                 first_i
);
  a_r1_quiet_before_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_i |-> (stall_o == '0 && !best_effort_o));

  a_r5_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_i));

  a_r6_hard_never_granted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_i & hard_i) == '0);

  a_r7_release_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    best_effort_o |-> stall_o == '0);

  a_r7_hold_to_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (best_effort_o && !boundary_i) |=> best_effort_o);

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_chk
    a_r5_grant_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_i[g] && !boundary_i) |=> !stall_o[g]);

    a_r2_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stall_o[g] && !grant_i[g] && !boundary_i) |=> (stall_o[g] || best_effort_o));
  end
endmodule

bind mem_bw_regulator mem_bw_regulator_chk #(.NUM_CORES(NUM_CORES)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .hard_i        (hard_i),
  .stall_o       (stall_o),
  .best_effort_o (best_effort_o),
  .grant_i       (grant_w),
  .boundary_i    (epoch_w.boundary),
  .first_i       (epoch_w.first)
);

// File: tb/mem_bw_regulator_tb_top.sv
module mem_bw_regulator_tb_top;
  localparam int N = 4;
  localparam int W = 8;
  localparam int P = 32;

  // {access[3:0], accepted core3..core0, best-effort cycles}
  localparam logic [43:0] VEC [5] = '{
    {4'b1111, 8'd32, 8'd24, 8'd20, 8'd18, 8'd16},  // R7 R8: budgets then best-effort
    {4'b0001, 8'd0,  8'd0,  8'd0,  8'd2,  8'd0},   // R2: core0 stops at its budget
    {4'b1000, 8'd21, 8'd0,  8'd0,  8'd0,  8'd0},   // R3 R5: core3 lives on quanta
    {4'b0000, 8'd0,  8'd0,  8'd0,  8'd0,  8'd0},   // R2: idle period
    {4'b0001, 8'd0,  8'd0,  8'd0,  8'd21, 8'd0}    // R4 R5: full donation reclaimed
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   access = '0;
  logic [N-1:0]   hard = '0;
  logic [N*W-1:0] budget = {8'd16, 8'd8, 8'd4, 8'd2};
  logic [N-1:0]   stall;
  logic           be;

  logic [N-1:0]   st;
  logic           be_s;
  int             acc_cnt [N];
  int             be_cnt;
  int             n_vec = 0;
  int             n_bad = 0;
  bit             done = 1'b0;

  always #2.5 clk = ~clk;

  mem_bw_regulator #(.NUM_CORES(N), .CNT_W(W), .PERIOD_CYCLES(P), .QUANTUM(2)) dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .access_i      (access),
    .hard_i        (hard),
    .budget_i      (budget),
    .stall_o       (stall),
    .best_effort_o (be)
  );

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] a);
    @(negedge clk);
    access = a;
    #1;
    st   = stall;
    be_s = be;
    for (int i = 0; i < N; i++) acc_cnt[i] += int'(a[i] & ~st[i]);
    be_cnt += int'(be_s);
  endtask

  task automatic clear_counts();
    for (int i = 0; i < N; i++) acc_cnt[i] = 0;
    be_cnt = 0;
  endtask

  task automatic run_period(input logic [N-1:0] a);
    clear_counts();
    for (int c = 0; c < P; c++) step(a);
  endtask

  initial begin
    #50000;
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    check("R1 stall in reset", int'(stall), 0);
    check("R1 best-effort in reset", int'(be), 0);
    @(negedge clk);
    rst_n = 1'b1;  // next posedge is the first boundary

    foreach (VEC[v]) begin
      run_period(VEC[v][43:40]);
      for (int i = 0; i < N; i++)
        check($sformatf("R2/R8 vec%0d core%0d accepted", v, i), acc_cnt[i],
              int'(VEC[v][8 + i*W +: W]));
      check($sformatf("R7 vec%0d best-effort cycles", v), be_cnt, int'(VEC[v][7:0]));
    end

    // R5: contention, lowest index first, one quantum per cycle
    clear_counts();
    for (int c = 0; c < P; c++) begin
      step(4'b1111);
      if (c == 0) check("R5 stall cycle0", int'(st), int'(4'b1110));
      if (c == 1) check("R5 stall cycle1", int'(st), int'(4'b1100));
      if (c == 2) check("R5 stall cycle2", int'(st), int'(4'b1001));
    end

    // R6: idle period, then core1 hard while the others donate everything
    run_period(4'b0000);
    hard = 4'b0010;
    begin
      int early = 0;
      clear_counts();
      for (int c = 0; c < P; c++) begin
        step(4'b0010);
        if (c < 4 && st[1]) early++;
        if (c == 4) check("R6 hard core stalls after budget", int'(st[1]), 1);
      end
      check("R6 hard core stalled before budget", early, 0);
      check("R6 hard core accepted no reclaim", acc_cnt[1], 4);
    end

    // R4: unused pool of 26 is discarded; only core0's 2 remain to reclaim
    hard = 4'b1110;
    run_period(4'b0001);
    check("R4 pool cleared at boundary", acc_cnt[0], 2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule